// File: doc/BRIEF.md
# Module-Description DRAM Configuration Builder

This block turns the contents of a DRAM module's description memory into the controller configuration bytes the memory controller needs before it leaves reset. After a `start` pulse it fetches twelve description bytes, one at a time, over a simple byte-read port. The port carries an address, a request level, and a response that returns data, a valid strobe and an error flag. It keeps the fetched bytes and derives four things from them: the address-map type, the end address of rank 0, the cumulative end address used for ranks 1 to 3, and a timing byte. The timing byte packs CAS latency, precharge, RAS-to-CAS, active-time and internal-bank interleave choices.

The results go out on a register-write port as six address/data pairs on back-to-back cycles. A one-cycle `done` strobe follows them. The CAS rule can pick a latency below the highest one the module advertises when the module's cycle time at that lower latency is fast enough. If any read response carries the error flag, the run stops at once and `errOut` goes high. No register write follows, and `errOut` stays high until the next `start`.

Top module: `spd_timing_encoder`

## Requirements
- R1: After `start` in idle, the block reads description addresses 17, 3, 13, 4, 31, 5, 18, 23, 25, 27, 29, 30 in that order. It has one read outstanding at a time, and it holds `rdReq` and `rdAddr` steady until a cycle with `rdValid` high.
- R2: After the last read is accepted, `wrValid` is high for exactly six consecutive cycles with `wrAddr` 0, 1, 2, 3, 4, 5. Slot 0 is the map type, slot 1 the rank-0 end, slots 2 to 4 the ranks 1–3 end, and slot 5 the timing byte.
- R3: Map type (slot 0) is 0x00 when byte 17 equals 2. Otherwise bit 7 is set when byte 3 ≥ 13 and byte 13 ≠ 4. A column count (byte 4) of 10 or 11 adds 0x60, 9 adds 0x40 and 8 adds 0x20.
- R4: Rank-0 end (slot 1) is a priority encoding of byte 31, tested from the highest priority down. Bit1 gives 0x80, bit0 0x40, bit7 0x20, bit6 0x10, bit5 0x08, bit4 0x04, bit3 0x02 and bit2 0x01. It is 0x01 when no bit is set.
- R5: Slots 2 to 4 carry the slot-1 value shifted left by one (truncated to 8 bits) when byte 5 equals 2, and the slot-1 value unchanged otherwise.
- R6: CAS field, timing bits [5:4]: 01 means CL2, 10 means CL2.5 and 11 means CL3. When byte 18 bit4 is set, start at 11. Change to 10 if byte 18 bit3 is set and byte 23 ≤ 0x75. Then change to 01 if byte 18 bit2 is set and byte 25 ≤ 0x75.
- R7: When byte 18 bit4 is clear, the CAS field is 10, changed to 01 if byte 18 bit2 is set and byte 23 ≤ 0x75.
- R8: Timing bit 7 is set when byte 27 > 0x3C, bit 2 when byte 29 > 0x3C, and bit 6 when byte 30 > 0x25. Bit 3 is always 0.
- R9: Timing bits [1:0] are 10 when byte 17 equals 4, 01 when it equals 2, and 00 otherwise.
- R10: `done` is high for exactly one cycle, the cycle right after the slot-5 write.
- R11: A read response with `rdErr` high ends the run. `errOut` rises the next cycle, no further read or write is issued, and `done` does not pulse. The next `start` clears `errOut`.
- R12: `start` is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle or after an error |
| rdReq | output | 1 | Byte-read request, held until answered |
| rdAddr | output | 8 | Description byte address |
| rdValid | input | 1 | Read response strobe |
| rdData | input | 8 | Read response byte |
| rdErr | input | 1 | Read response error flag, sampled with rdValid |
| wrValid | output | 1 | Register-write strobe |
| wrAddr | output | 3 | Configuration slot index 0..5 |
| wrData | output | 8 | Configuration byte |
| done | output | 1 | One-cycle completion strobe |
| errOut | output | 1 | Run aborted by a read error |

## Verification
An error can arrive on the same cycle as the final read response, and that response would otherwise launch the write burst. The bench provokes this by flagging the twelfth response. It judges the result by seeing no write and no `done`, with `errOut` high and exactly twelve reads issued. A stray `start` pulse is also dropped into the middle of a read sequence, where it lands alongside response handling. It must not restart the address order or add writes.

// File: rtl/spd_enc_pkg.sv
package spd_enc_pkg;

  localparam int ByteW     = 8;
  localparam int NumReads  = 12;
  localparam int NumWrites = 6;
  localparam int RdIdxW    = $clog2(NumReads);
  localparam int WrIdxW    = $clog2(NumWrites);

  // slot positions of the fetched bytes, in fetch order
  localparam int IxBanks   = 0;
  localparam int IxRows    = 1;
  localparam int IxWidth   = 2;
  localparam int IxCols    = 3;
  localparam int IxDens    = 4;
  localparam int IxRanks   = 5;
  localparam int IxCasSup  = 6;
  localparam int IxCycHalf = 7;
  localparam int IxCycOne  = 8;
  localparam int IxTrp     = 9;
  localparam int IxTrcd    = 10;
  localparam int IxTras    = 11;

  // output slot positions
  localparam int WsMap    = 0;
  localparam int WsEnd0   = 1;
  localparam int WsTiming = 5;

  typedef enum logic [2:0] {
    StIdle,
    StRead,
    StWrite,
    StDone,
    StErr
  } ctrlState_t;

  typedef struct packed {
    logic              capture;
    logic [RdIdxW-1:0] rdIdx;
    logic [WrIdxW-1:0] wrIdx;
  } dpStrobe_t;

  function automatic logic [ByteW-1:0] readAddrOf(input logic [RdIdxW-1:0] idx);
    case (idx)
      RdIdxW'(IxBanks):   readAddrOf = ByteW'(17);
      RdIdxW'(IxRows):    readAddrOf = ByteW'(3);
      RdIdxW'(IxWidth):   readAddrOf = ByteW'(13);
      RdIdxW'(IxCols):    readAddrOf = ByteW'(4);
      RdIdxW'(IxDens):    readAddrOf = ByteW'(31);
      RdIdxW'(IxRanks):   readAddrOf = ByteW'(5);
      RdIdxW'(IxCasSup):  readAddrOf = ByteW'(18);
      RdIdxW'(IxCycHalf): readAddrOf = ByteW'(23);
      RdIdxW'(IxCycOne):  readAddrOf = ByteW'(25);
      RdIdxW'(IxTrp):     readAddrOf = ByteW'(27);
      RdIdxW'(IxTrcd):    readAddrOf = ByteW'(29);
      RdIdxW'(IxTras):    readAddrOf = ByteW'(30);
      default:            readAddrOf = '0;
    endcase
  endfunction

endpackage

// File: rtl/spd_enc_ctrl.sv
module spd_enc_ctrl
  import spd_enc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      rdValid,
  input  logic      rdErr,
  output logic      rdReq,
  output logic      wrValid,
  output logic      done,
  output logic      errOut,
  output dpStrobe_t strobe
);

  localparam logic [RdIdxW-1:0] LastRd = RdIdxW'(NumReads - 1);
  localparam logic [WrIdxW-1:0] LastWr = WrIdxW'(NumWrites - 1);

  ctrlState_t        state;
  logic [RdIdxW-1:0] rdIdx;
  logic [WrIdxW-1:0] wrIdx;
  logic              errQ;

  wire respOk  = (state == StRead) && rdValid && !rdErr;
  wire respBad = (state == StRead) && rdValid && rdErr;
  wire canGo   = (state == StIdle) || (state == StErr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= StIdle;
      rdIdx <= '0;
      wrIdx <= '0;
      errQ  <= 1'b0;
    end else begin
      case (state)
        StIdle, StErr: begin
          if (start) begin
            state <= StRead;
            rdIdx <= '0;
            errQ  <= 1'b0;
          end
        end
        StRead: begin
          if (respBad) begin
            state <= StErr;
            errQ  <= 1'b1;
          end else if (respOk) begin
            if (rdIdx == LastRd) begin
              state <= StWrite;
              wrIdx <= '0;
            end else begin
              rdIdx <= rdIdx + 1'b1;
            end
          end
        end
        StWrite: begin
          if (wrIdx == LastWr) state <= StDone;
          else                 wrIdx <= wrIdx + 1'b1;
        end
        StDone:  state <= StIdle;
        default: state <= StIdle;
      endcase
    end
  end

  assign rdReq          = (state == StRead);
  assign wrValid        = (state == StWrite);
  assign done           = (state == StDone);
  assign errOut         = errQ;
  assign strobe.capture = respOk;
  assign strobe.rdIdx   = rdIdx;
  assign strobe.wrIdx   = wrIdx;

  // R1: an unanswered request stays up at the same slot
  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdValid |=> rdReq && $stable(rdIdx));

  // R2: write slots advance by one each cycle until the last
  assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && (wrIdx != LastWr) |=> wrValid && (wrIdx == $past(wrIdx) + 1'b1));

  // R10: done follows the final write
  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && (wrIdx == LastWr) |=> done && !wrValid);

  // R11: an error response aborts with no write
  assert_err_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && rdValid && rdErr |=> errOut && !wrValid && !rdReq && !done);

  // R12: start while busy leaves the read slot unchanged
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    start && rdReq && !rdValid |=> rdReq && $stable(rdIdx));

  // R11: an error never coexists with traffic
  assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> !wrValid && !done);

  logic unusedCanGo;
  assign unusedCanGo = canGo;

endmodule

// File: rtl/spd_enc_datapath.sv
module spd_enc_datapath
  import spd_enc_pkg::*;
#(
  parameter logic [ByteW-1:0] CycleLimit = 8'h75,
  parameter logic [ByteW-1:0] TrpLimit   = 8'h3C,
  parameter logic [ByteW-1:0] TrcdLimit  = 8'h3C,
  parameter logic [ByteW-1:0] TrasLimit  = 8'h25
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [ByteW-1:0] rdData,
  output logic [ByteW-1:0] rdAddr,
  output logic [ByteW-1:0] wrData
);

  logic [NumReads-1:0][ByteW-1:0] slotQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ <= '0;
    end else if (strobe.capture) begin
      for (int i = 0; i < NumReads; i++) begin
        if (strobe.rdIdx == RdIdxW'(i)) slotQ[i] <= rdData;
      end
    end
  end

  assign rdAddr = readAddrOf(strobe.rdIdx);

  logic [ByteW-1:0] banks, rows, devWidth, cols, dens, ranks;
  logic [ByteW-1:0] casSup, cycHalf, cycOne, trp, trcd, tras;

  assign banks    = slotQ[IxBanks];
  assign rows     = slotQ[IxRows];
  assign devWidth = slotQ[IxWidth];
  assign cols     = slotQ[IxCols];
  assign dens     = slotQ[IxDens];
  assign ranks    = slotQ[IxRanks];
  assign casSup   = slotQ[IxCasSup];
  assign cycHalf  = slotQ[IxCycHalf];
  assign cycOne   = slotQ[IxCycOne];
  assign trp      = slotQ[IxTrp];
  assign trcd     = slotQ[IxTrcd];
  assign tras     = slotQ[IxTras];

  // address-map type
  logic [ByteW-1:0] mapType;
  always_comb begin
    mapType = '0;
    if (banks != ByteW'(2)) begin
      if ((rows >= ByteW'(13)) && (devWidth != ByteW'(4))) mapType[7] = 1'b1;
      if ((cols == ByteW'(10)) || (cols == ByteW'(11))) mapType[6:5] = 2'b11;
      else if (cols == ByteW'(9))                       mapType[6:5] = 2'b10;
      else if (cols == ByteW'(8))                       mapType[6:5] = 2'b01;
    end
  end

  // rank density priority encoder
  logic [ByteW-1:0] end0;
  always_comb begin
    if      (dens[1]) end0 = 8'h80;
    else if (dens[0]) end0 = 8'h40;
    else if (dens[7]) end0 = 8'h20;
    else if (dens[6]) end0 = 8'h10;
    else if (dens[5]) end0 = 8'h08;
    else if (dens[4]) end0 = 8'h04;
    else if (dens[3]) end0 = 8'h02;
    else              end0 = 8'h01;
  end

  logic [ByteW-1:0] endRest;
  assign endRest = (ranks == ByteW'(2)) ? {end0[ByteW-2:0], 1'b0} : end0;

  // CAS latency selection
  logic [1:0] casField;
  always_comb begin
    if (casSup[4]) begin
      casField = 2'b11;
      if (casSup[3] && (cycHalf <= CycleLimit)) casField = 2'b10;
      if (casSup[2] && (cycOne <= CycleLimit))  casField = 2'b01;
    end else begin
      casField = 2'b10;
      if (casSup[2] && (cycHalf <= CycleLimit)) casField = 2'b01;
    end
  end

  logic [1:0] ilv;
  always_comb begin
    if      (banks == ByteW'(4)) ilv = 2'b10;
    else if (banks == ByteW'(2)) ilv = 2'b01;
    else                         ilv = 2'b00;
  end

  logic [ByteW-1:0] timing;
  assign timing = {trp > TrpLimit, tras > TrasLimit, casField, 1'b0, trcd > TrcdLimit, ilv};

  always_comb begin
    case (strobe.wrIdx)
      WrIdxW'(WsMap):    wrData = mapType;
      WrIdxW'(WsEnd0):   wrData = end0;
      WrIdxW'(WsTiming): wrData = timing;
      default:           wrData = (strobe.wrIdx < WrIdxW'(NumWrites)) ? endRest : '0;
    endcase
  end

  // R4: the rank end is always a single set bit
  assert_end_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(end0) == 1);

  // R6: captured CAS field never holds the unused code
  assert_cas_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> timing[5:4] != 2'b00);

endmodule

// File: rtl/spd_timing_encoder.sv
module spd_timing_encoder
  import spd_enc_pkg::*;
#(
  parameter logic [7:0] CycleLimit = 8'h75,
  parameter logic [7:0] TrpLimit   = 8'h3C,
  parameter logic [7:0] TrcdLimit  = 8'h3C,
  parameter logic [7:0] TrasLimit  = 8'h25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output logic       rdReq,
  output logic [7:0] rdAddr,
  input  logic       rdValid,
  input  logic [7:0] rdData,
  input  logic       rdErr,
  output logic       wrValid,
  output logic [2:0] wrAddr,
  output logic [7:0] wrData,
  output logic       done,
  output logic       errOut
);

  dpStrobe_t strobe;

  spd_enc_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rdValid (rdValid),
    .rdErr   (rdErr),
    .rdReq   (rdReq),
    .wrValid (wrValid),
    .done    (done),
    .errOut  (errOut),
    .strobe  (strobe)
  );

  spd_enc_datapath #(
    .CycleLimit (CycleLimit),
    .TrpLimit   (TrpLimit),
    .TrcdLimit  (TrcdLimit),
    .TrasLimit  (TrasLimit)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdData (rdData),
    .rdAddr (rdAddr),
    .wrData (wrData)
  );

  assign wrAddr = 3'(strobe.wrIdx);

endmodule

// File: tb/spd_timing_encoder_test.sv
`timescale 1ns/1ps
module spd_timing_encoder_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       rdReq;
  logic [7:0] rdAddr;
  logic       rdValid = 1'b0;
  logic [7:0] rdData = '0;
  logic       rdErr = 1'b0;
  logic       wrValid;
  logic [2:0] wrAddr;
  logic [7:0] wrData;
  logic       done;
  logic       errOut;

  always #2.5 clk = ~clk;

  spd_timing_encoder uut (
    .clk(clk), .rstN(rstN), .start(start),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .done(done), .errOut(errOut)
  );

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;

  logic [7:0] spdB [12];
  logic [7:0] addrOrder [12] = '{8'd17, 8'd3, 8'd13, 8'd4, 8'd31, 8'd5,
                                 8'd18, 8'd23, 8'd25, 8'd27, 8'd29, 8'd30};
  int rdCount, wrCount, doneCount, errAt, lastWrCycle, doneCycle, waitCnt;
  logic [2:0] wrA [16];
  logic [7:0] wrD [16];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected values from the requirements
  function automatic logic [7:0] expMap();
    logic [7:0] c = 0;
    if (spdB[0] == 2) return 8'h00;
    if (spdB[1] >= 13 && spdB[2] != 4) c = 8'h80;
    if (spdB[3] == 10 || spdB[3] == 11) c |= 8'h60;
    else if (spdB[3] == 9) c |= 8'h40;
    else if (spdB[3] == 8) c |= 8'h20;
    return c;
  endfunction

  function automatic logic [7:0] expEnd0();
    int bitPri [8] = '{1, 0, 7, 6, 5, 4, 3, 2};
    for (int k = 0; k < 8; k++)
      if (spdB[4][bitPri[k]]) return 8'h80 >> k;
    return 8'h01;
  endfunction

  function automatic logic [7:0] expEndRest();
    logic [7:0] e = expEnd0();
    return (spdB[5] == 2) ? (e << 1) : e;
  endfunction

  function automatic logic [7:0] expTiming();
    logic [7:0] t = 0;
    logic [1:0] cl;
    if (spdB[6][4]) begin
      cl = 2'b11;
      if (spdB[6][3] && spdB[7] <= 8'h75) cl = 2'b10;
      if (spdB[6][2] && spdB[8] <= 8'h75) cl = 2'b01;
    end else begin
      cl = 2'b10;
      if (spdB[6][2] && spdB[7] <= 8'h75) cl = 2'b01;
    end
    t[5:4] = cl;
    t[7] = spdB[9] > 8'h3C;
    t[2] = spdB[10] > 8'h3C;
    t[6] = spdB[11] > 8'h25;
    if (spdB[0] == 4) t[1:0] = 2'b10;
    else if (spdB[0] == 2) t[1:0] = 2'b01;
    return t;
  endfunction

  // responder, monitor and watchdog
  initial begin
    waitCnt = 0;
    forever begin
      @(negedge clk);
      cycle++;
      if (wrValid) begin
        if (wrCount < 16) begin
          wrA[wrCount] = wrAddr;
          wrD[wrCount] = wrData;
        end
        wrCount++;
        lastWrCycle = cycle;
      end
      if (done) begin
        doneCount++;
        doneCycle = cycle;
      end
      if (rdValid) begin
        rdValid = 1'b0;
        rdErr   = 1'b0;
      end else if (rdReq) begin
        if (waitCnt > 0) waitCnt--;
        else begin
          if (rdCount < 12) check(rdAddr == addrOrder[rdCount], "R1 read address", rdAddr, addrOrder[rdCount]);
          else check(1'b0, "R1 read count", rdCount + 1, 12);
          rdData  = spdB[rdCount < 12 ? rdCount : 0];
          rdErr   = (rdCount == errAt);
          rdValid = 1'b1;
          rdCount++;
          waitCnt = $urandom % 3;
        end
      end
      if (cycle > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycle);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  task automatic runVec(input int errPos, input bit poke);
    int n;
    rdCount = 0; wrCount = 0; doneCount = 0; errAt = errPos;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(errOut == 1'b0, "R11 start clears error", errOut, 0);
    n = 0;
    while (doneCount == 0 && !errOut && n < 500) begin
      @(negedge clk);
      n++;
      if (poke && n == 5) start = 1'b1;       // R12 stray start
      if (poke && n == 6) start = 1'b0;
    end
    start = 1'b0;
    repeat (6) @(negedge clk);
    if (errPos < 0) begin
      check(wrCount == 6, "R2 write count", wrCount, 6);
      check(rdCount == 12, "R12 read count", rdCount, 12);
      for (int k = 0; k < 6 && k < wrCount; k++)
        check(wrA[k] == 3'(k), "R2 write slot", wrA[k], k);
      if (wrCount == 6) begin
        check(wrD[0] == expMap(), "R3 map type", wrD[0], expMap());
        check(wrD[1] == expEnd0(), "R4 rank end", wrD[1], expEnd0());
        for (int k = 2; k < 5; k++)
          check(wrD[k] == expEndRest(), "R5 later rank end", wrD[k], expEndRest());
        check(wrD[5][5:4] == expTiming()[5:4], spdB[6][4] ? "R6 CAS field" : "R7 CAS field",
              wrD[5][5:4], expTiming()[5:4]);
        check({wrD[5][7:6], wrD[5][3:2]} == {expTiming()[7:6], expTiming()[3:2]},
              "R8 timing bits", wrD[5], expTiming());
        check(wrD[5][1:0] == expTiming()[1:0], "R9 interleave", wrD[5][1:0], expTiming()[1:0]);
      end
      check(doneCount == 1, "R10 done count", doneCount, 1);
      check(doneCycle == lastWrCycle + 1, "R10 done timing", doneCycle - lastWrCycle, 1);
    end else begin
      check(wrCount == 0, "R11 no writes", wrCount, 0);
      check(doneCount == 0, "R11 no done", doneCount, 0);
      check(errOut == 1'b1, "R11 error out", errOut, 1);
      check(rdCount == errPos + 1, "R11 reads stop", rdCount, errPos + 1);
    end
  endtask

  function automatic logic [7:0] pick4(input logic [7:0] a, b, c, d);
    case ($urandom % 4)
      0: return a;
      1: return b;
      2: return c;
      default: return d;
    endcase
  endfunction

  task automatic randSpd();
    spdB[0]  = pick4(8'd2, 8'd4, 8'd4, 8'($urandom));
    spdB[1]  = pick4(8'd12, 8'd13, 8'd14, 8'($urandom % 16));
    spdB[2]  = pick4(8'd4, 8'd8, 8'd16, 8'd4);
    spdB[3]  = pick4(8'd8, 8'd9, 8'd10, 8'd8 + 8'($urandom % 5));
    spdB[4]  = ($urandom % 6 == 0) ? 8'h00 : 8'($urandom);
    spdB[5]  = pick4(8'd1, 8'd2, 8'd2, 8'($urandom % 4));
    spdB[6]  = 8'($urandom);
    spdB[7]  = pick4(8'h74, 8'h75, 8'h76, 8'($urandom));
    spdB[8]  = pick4(8'h74, 8'h75, 8'h76, 8'($urandom));
    spdB[9]  = pick4(8'h3B, 8'h3C, 8'h3D, 8'($urandom));
    spdB[10] = pick4(8'h3B, 8'h3C, 8'h3D, 8'($urandom));
    spdB[11] = pick4(8'h24, 8'h25, 8'h26, 8'($urandom));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 12; k++) spdB[k] = '0;
    repeat (3) @(negedge clk);
    check(rdReq == 0 && wrValid == 0 && done == 0 && errOut == 0, "R1 reset idle",
          {rdReq, wrValid, done, errOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdReq == 0, "R1 idle without start", rdReq, 0);

    // directed: all-zero density, CL3 kept, no interleave
    spdB = '{8'd8, 8'd13, 8'd8, 8'd10, 8'h00, 8'd1, 8'h10, 8'h80, 8'h80, 8'h3D, 8'h3C, 8'h26};
    runVec(-1, 1'b0);
    // directed: bit1 beats everything, dual rank overflow, CL2 via byte 25
    spdB = '{8'd4, 8'd12, 8'd4, 8'd9, 8'hFF, 8'd2, 8'h1C, 8'h75, 8'h75, 8'h3C, 8'h3D, 8'h25};
    runVec(-1, 1'b0);
    // directed: byte17 == 2 gives map 0, CL2 via byte 23 without CL3
    spdB = '{8'd2, 8'd14, 8'd8, 8'd11, 8'h04, 8'd2, 8'h0C, 8'h70, 8'hFF, 8'h00, 8'h00, 8'h00};
    runVec(-1, 1'b0);
    // directed: stray start mid-run
    runVec(-1, 1'b1);
    // directed: error on final read (same cycle as write launch), then first read
    runVec(11, 1'b0);
    runVec(0, 1'b0);
    runVec(-1, 1'b0);

    for (int v = 0; v < 40; v++) begin
      randSpd();
      if (v % 8 == 7) runVec(int'($urandom % 12), 1'b0);
      else runVec(-1, (v % 5) == 2);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule